// File: doc/BRIEF.md
# Chip-Select Bus-Cycle Termination Controller

This block ends asynchronous bus cycles for a single SRAM-style memory bank that sits behind a chip select. A small configuration register holds three settings. The first is the bank type. The second is a two-bit port-size code, which either names the data width the bank returns or says that termination is left to the outside. The third is a wait-state count. The bank type and port size load to SRAM and 32-bit out of reset, and the wait count loads to the value a boot bank needs.

When a cycle starts with the address strobe and the chip select both low, the block loads its wait counter. When the counter runs out, it drives an active-low acknowledge pair whose pattern encodes the port width. It keeps watching the external acknowledge lines throughout, so that an agent outside the block can end the cycle early. In the alternate bus mode, the block uses one transfer-acknowledge wire instead of the pair, and it samples that wire on the rising clock edge rather than the falling one.

Each termination produces a one-cycle done pulse and a flag that records whether the block or an external agent ended the cycle. Every output returns to the negated state once the address strobe rises.

Top module: `cs_cycle_term`

## Requirements
- R1: After reset, all outputs are negated (ack_oe_o=0, ack_n_o=2'b11, ta_oe_o=0, ta_n_o=1, done_o=0, done_ext_o=0). The configuration resets to SRAM, port code 00 and BOOT_WAITS wait states (default 14).
- R2: The start edge is the first rising edge, while idle, at which as_n_i and cs_n_i are both low. With W wait states and an internal port code, the acknowledge becomes active on the rising edge that falls W+1 edges after the start edge.
- R3: The port code selects the acknowledge pattern driven with ack_oe_o=1. Code 00 (32-bit) drives ack_n_o=2'b00. Code 01 (16-bit) drives ack_n_o=2'b01, which asserts only bit 1. Code 10 (8-bit) drives ack_n_o=2'b10, which asserts only bit 0.
- R4: With port code 11, the block never drives an acknowledge (ack_oe_o and ta_oe_o stay 0), and only an external acknowledge ends the cycle.
- R5: The block samples ext_ack_n_i on every falling clock edge, whatever the port code. A low level on either bit ends the cycle at the next rising edge, with done_ext_o=1 and no acknowledge driven. If this coincides with the internal count running out, the external termination wins.
- R6: When bus_alt_i=1 and the port code is internal, the block drives ta_n_o=0 with ta_oe_o=1 in place of the pair, and the pair stays undriven. The timing is otherwise the same.
- R7: When bus_alt_i=1, the block samples ext_ta_n_i on rising edges. A low level first seen at one edge ends the cycle at the following rising edge.
- R8: An external acknowledge or transfer-acknowledge that is present only before the start edge does not end the cycle. Termination then follows R2.
- R9: When the bank type bit is 1 (DRAM), no cycle starts: no done pulse and no acknowledge are produced.
- R10: done_o is high for exactly one cycle after the terminating edge. done_ext_o gives the source (1 = external, 0 = internal) and holds its value until the next start edge.
- R11: All driven acknowledges are negated on the first rising edge at which as_n_i is high.
- R12: A high cfg_load_i at a rising edge captures cfg_dram_i, cfg_port_i and cfg_waits_i for later cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_load_i | input | 1 | Load strobe for the bank configuration |
| cfg_dram_i | input | 1 | Bank type: 0 = SRAM, 1 = DRAM |
| cfg_port_i | input | 2 | Port code: 00 = 32-bit, 01 = 16-bit, 10 = 8-bit, 11 = external |
| cfg_waits_i | input | WAIT_W | Wait-state count |
| bus_alt_i | input | 1 | Selects single transfer-acknowledge mode |
| as_n_i | input | 1 | Address strobe, active low |
| cs_n_i | input | 1 | Chip select, active low |
| ext_ack_n_i | input | 2 | External acknowledge pair, active low |
| ext_ta_n_i | input | 1 | External transfer-acknowledge, active low |
| ack_n_o | output | 2 | Acknowledge pair value |
| ack_oe_o | output | 1 | Drive enable for the acknowledge pair |
| ta_n_o | output | 1 | Transfer-acknowledge value |
| ta_oe_o | output | 1 | Drive enable for transfer-acknowledge |
| done_o | output | 1 | One-cycle termination pulse |
| done_ext_o | output | 1 | Termination source, 1 = external |

## Verification
The bench sweeps every internal port code against wait counts of 0, 5, 10 and 15 in both bus modes. A design whose counter is off by one acknowledges one edge early or late. A design with swapped width bits shows the wrong pair pattern. The bench also forces a tie between an external and an internal termination; a design that favours its own count would drive the pair and clear done_ext_o. A transfer-acknowledge pulse placed just before the chip select is used to catch a design that accepts a stale sample and ends the cycle at once. A DRAM setting and the untouched boot configuration are checked as well, so that a wrong reset wait count or a bank-type bit that is ignored shows up.

// File: rtl/cs_term_pkg.sv
package cs_term_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_WAIT = 2'd1,
        ST_ACK  = 2'd2,
        ST_HOLD = 2'd3
    } term_state_e;

    typedef enum logic [1:0] {
        PS_32  = 2'b00,
        PS_16  = 2'b01,
        PS_8   = 2'b10,
        PS_EXT = 2'b11
    } port_sz_e;

    // Active-low pair pattern for a given width: bit 1 is the upper line.
    function automatic logic [1:0] width_code(input port_sz_e ps);
        case (ps)
            PS_32:   width_code = 2'b00;
            PS_16:   width_code = 2'b01;
            PS_8:    width_code = 2'b10;
            default: width_code = 2'b11;
        endcase
    endfunction

endpackage

// File: rtl/cs_term_cfg.sv
module cs_term_cfg
    import cs_term_pkg::*;
#(
    parameter int WAIT_W     = 4,
    parameter int BOOT_WAITS = 14
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_i,
    input  logic              dram_i,
    input  logic [1:0]        port_i,
    input  logic [WAIT_W-1:0] waits_i,
    output logic              dram_o,
    output port_sz_e          port_o,
    output logic [WAIT_W-1:0] waits_o
);

    typedef struct packed {
        logic              dram;
        port_sz_e          port;
        logic [WAIT_W-1:0] waits;
    } cfg_t;

    cfg_t cfg_d, cfg_q;

    always_comb begin
        cfg_d = cfg_q;
        if (load_i) begin
            cfg_d.dram  = dram_i;
            cfg_d.port  = port_sz_e'(port_i);
            cfg_d.waits = waits_i;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg_q.dram  <= 1'b0;
            cfg_q.port  <= PS_32;
            cfg_q.waits <= WAIT_W'(BOOT_WAITS);
        end else begin
            cfg_q <= cfg_d;
        end
    end

    assign dram_o  = cfg_q.dram;
    assign port_o  = cfg_q.port;
    assign waits_o = cfg_q.waits;

endmodule

// File: rtl/cs_term_sampler.sv
module cs_term_sampler #(
    parameter int PAIR_W = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [PAIR_W-1:0] ext_ack_n_i,
    input  logic              ext_ta_n_i,
    output logic              pair_seen_o,
    output logic              ta_seen_o
);

    logic pair_seen_d, pair_seen_q;
    logic ta_seen_d, ta_seen_q;

    always_comb begin
        pair_seen_d = ~&ext_ack_n_i;
        ta_seen_d   = ~ext_ta_n_i;
    end

    // Pair is captured mid-cycle on the falling edge.
    always_ff @(negedge clk or negedge rst_n) begin
        if (!rst_n) pair_seen_q <= 1'b0;
        else        pair_seen_q <= pair_seen_d;
    end

    // Single transfer-acknowledge is captured on the rising edge.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ta_seen_q <= 1'b0;
        else        ta_seen_q <= ta_seen_d;
    end

    assign pair_seen_o = pair_seen_q;
    assign ta_seen_o   = ta_seen_q;

endmodule

// File: rtl/cs_term_fsm.sv
module cs_term_fsm
    import cs_term_pkg::*;
#(
    parameter int WAIT_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              as_n_i,
    input  logic              cs_n_i,
    input  logic              dram_i,
    input  port_sz_e          port_i,
    input  logic [WAIT_W-1:0] waits_i,
    input  logic              alt_i,
    input  logic              pair_seen_i,
    input  logic              ta_seen_i,
    output logic [1:0]        ack_n_o,
    output logic              ack_oe_o,
    output logic              ta_n_o,
    output logic              ta_oe_o,
    output logic              done_o,
    output logic              done_ext_o
);

    typedef struct packed {
        term_state_e       state;
        logic [WAIT_W-1:0] cnt;
        logic [1:0]        ack_n;
        logic              ack_oe;
        logic              ta_n;
        logic              ta_oe;
        logic              done;
        logic              done_ext;
    } fsm_t;

    fsm_t s_d, s_q;
    logic ext_hit;

    always_comb begin
        s_d      = s_q;
        s_d.done = 1'b0;
        ext_hit  = alt_i ? ta_seen_i : pair_seen_i;
        case (s_q.state)
            ST_IDLE: begin
                if (!as_n_i && !cs_n_i && !dram_i) begin
                    s_d.state    = ST_WAIT;
                    s_d.cnt      = waits_i;
                    s_d.done_ext = 1'b0;
                end
            end
            ST_WAIT: begin
                if (as_n_i) begin
                    s_d.state = ST_IDLE;
                end else if (ext_hit) begin
                    s_d.state    = ST_HOLD;
                    s_d.done     = 1'b1;
                    s_d.done_ext = 1'b1;
                end else if (port_i != PS_EXT && s_q.cnt == '0) begin
                    s_d.state    = ST_ACK;
                    s_d.done     = 1'b1;
                    s_d.done_ext = 1'b0;
                    if (alt_i) begin
                        s_d.ta_n  = 1'b0;
                        s_d.ta_oe = 1'b1;
                    end else begin
                        s_d.ack_n  = width_code(port_i);
                        s_d.ack_oe = 1'b1;
                    end
                end else if (s_q.cnt != '0) begin
                    s_d.cnt = s_q.cnt - 1'b1;
                end
            end
            default: begin
                if (as_n_i) begin
                    s_d.state  = ST_IDLE;
                    s_d.ack_n  = 2'b11;
                    s_d.ack_oe = 1'b0;
                    s_d.ta_n   = 1'b1;
                    s_d.ta_oe  = 1'b0;
                end
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q.state    <= ST_IDLE;
            s_q.cnt      <= '0;
            s_q.ack_n    <= 2'b11;
            s_q.ack_oe   <= 1'b0;
            s_q.ta_n     <= 1'b1;
            s_q.ta_oe    <= 1'b0;
            s_q.done     <= 1'b0;
            s_q.done_ext <= 1'b0;
        end else begin
            s_q <= s_d;
        end
    end

    assign ack_n_o    = s_q.ack_n;
    assign ack_oe_o   = s_q.ack_oe;
    assign ta_n_o     = s_q.ta_n;
    assign ta_oe_o    = s_q.ta_oe;
    assign done_o     = s_q.done;
    assign done_ext_o = s_q.done_ext;

endmodule

// File: rtl/cs_cycle_term.sv
module cs_cycle_term
    import cs_term_pkg::*;
#(
    parameter int WAIT_W     = 4,
    parameter int BOOT_WAITS = 14
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_load_i,
    input  logic              cfg_dram_i,
    input  logic [1:0]        cfg_port_i,
    input  logic [WAIT_W-1:0] cfg_waits_i,
    input  logic              bus_alt_i,
    input  logic              as_n_i,
    input  logic              cs_n_i,
    input  logic [1:0]        ext_ack_n_i,
    input  logic              ext_ta_n_i,
    output logic [1:0]        ack_n_o,
    output logic              ack_oe_o,
    output logic              ta_n_o,
    output logic              ta_oe_o,
    output logic              done_o,
    output logic              done_ext_o
);

    logic              cfg_dram_q;
    port_sz_e          cfg_port_q;
    logic [WAIT_W-1:0] cfg_waits_q;
    logic              pair_seen;
    logic              ta_seen;

    cs_term_cfg #(
        .WAIT_W     (WAIT_W),
        .BOOT_WAITS (BOOT_WAITS)
    ) u_cfg (
        .clk     (clk),
        .rst_n   (rst_n),
        .load_i  (cfg_load_i),
        .dram_i  (cfg_dram_i),
        .port_i  (cfg_port_i),
        .waits_i (cfg_waits_i),
        .dram_o  (cfg_dram_q),
        .port_o  (cfg_port_q),
        .waits_o (cfg_waits_q)
    );

    cs_term_sampler #(
        .PAIR_W (2)
    ) u_smp (
        .clk         (clk),
        .rst_n       (rst_n),
        .ext_ack_n_i (ext_ack_n_i),
        .ext_ta_n_i  (ext_ta_n_i),
        .pair_seen_o (pair_seen),
        .ta_seen_o   (ta_seen)
    );

    cs_term_fsm #(
        .WAIT_W (WAIT_W)
    ) u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .as_n_i      (as_n_i),
        .cs_n_i      (cs_n_i),
        .dram_i      (cfg_dram_q),
        .port_i      (cfg_port_q),
        .waits_i     (cfg_waits_q),
        .alt_i       (bus_alt_i),
        .pair_seen_i (pair_seen),
        .ta_seen_i   (ta_seen),
        .ack_n_o     (ack_n_o),
        .ack_oe_o    (ack_oe_o),
        .ta_n_o      (ta_n_o),
        .ta_oe_o     (ta_oe_o),
        .done_o      (done_o),
        .done_ext_o  (done_ext_o)
    );

endmodule

// File: rtl/cs_term_chk.sv
module cs_term_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       as_n,
    input logic [1:0] ack_n,
    input logic       ack_oe,
    input logic       ta_oe,
    input logic       done,
    input logic       done_ext,
    input logic       dram_q,
    input logic [1:0] port_q
);

    AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R10

    AST_EXT_PORT_NO_DRIVE: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(ack_oe) || $rose(ta_oe)) |-> ($past(port_q) != 2'b11)); // R4

    AST_ONE_ACK_STYLE: assert property (@(posedge clk) disable iff (!rst_n)
        ack_oe |-> !ta_oe); // R6

    AST_PAIR_CODE_LIVE: assert property (@(posedge clk) disable iff (!rst_n)
        ack_oe |-> (ack_n != 2'b11)); // R3

    AST_RELEASE_ON_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_oe || ta_oe) |-> $past(!as_n)); // R11

    AST_EXT_END_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
        (done && done_ext) |-> (!ack_oe && !ta_oe)); // R5

    AST_DRAM_NO_END: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done) |-> !$past(dram_q)); // R9

endmodule

bind cs_cycle_term cs_term_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .as_n     (as_n_i),
    .ack_n    (ack_n_o),
    .ack_oe   (ack_oe_o),
    .ta_oe    (ta_oe_o),
    .done     (done_o),
    .done_ext (done_ext_o),
    .dram_q   (cfg_dram_q),
    .port_q   (cfg_port_q)
);

// File: tb/sim_cs_cycle_term.sv
`timescale 1ns/1ps
module sim_cs_cycle_term;

    localparam int INF = 1000;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cfg_load = 1'b0;
    logic       cfg_dram = 1'b0;
    logic [1:0] cfg_port = 2'b00;
    logic [3:0] cfg_waits = 4'd0;
    logic       bus_alt = 1'b0;
    logic       as_n = 1'b1;
    logic       cs_n = 1'b1;
    logic [1:0] ext_ack_n = 2'b11;
    logic       ext_ta_n = 1'b1;
    logic [1:0] ack_n;
    logic       ack_oe, ta_n, ta_oe, done, done_ext;

    int total = 0;
    int bad = 0;
    bit finished = 1'b0;

    always #4 clk = ~clk;

    cs_cycle_term #(.WAIT_W(4), .BOOT_WAITS(14)) u0 (
        .clk(clk), .rst_n(rst_n), .cfg_load_i(cfg_load), .cfg_dram_i(cfg_dram),
        .cfg_port_i(cfg_port), .cfg_waits_i(cfg_waits), .bus_alt_i(bus_alt),
        .as_n_i(as_n), .cs_n_i(cs_n), .ext_ack_n_i(ext_ack_n), .ext_ta_n_i(ext_ta_n),
        .ack_n_o(ack_n), .ack_oe_o(ack_oe), .ta_n_o(ta_n), .ta_oe_o(ta_oe),
        .done_o(done), .done_ext_o(done_ext)
    );

    function automatic logic [5:0] outs();
        return {ack_oe, ack_n, ta_oe, ta_n, done};
    endfunction

    task automatic chk(input string req, input logic [5:0] act, input logic [5:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%b expected=%b at %0t", req, act, exp, $time);
        end
    endtask

    task automatic set_ext(input bit alt, input bit on);
        if (alt) ext_ta_n = !on;
        else     ext_ack_n = on ? 2'b00 : 2'b11;
    endtask

    // Expected timing is counted in observations k, each taken 1 ns after a
    // rising edge; the start edge is observation 1.
    task automatic run_cyc(input bit load, input bit dram, input logic [1:0] port,
                           input int waits, input bit alt, input int ext_at,
                           input bit pre_ext, input string req);
        int t_int, t_ext, t_end, lim;
        bit ext_won, drv;
        logic [1:0] enc;
        if (load) begin
            cfg_dram = dram; cfg_port = port; cfg_waits = 4'(waits); cfg_load = 1'b1;
            @(posedge clk); #1;
            cfg_load = 1'b0;
        end
        bus_alt = alt;
        if (pre_ext) begin
            set_ext(alt, 1'b1);
            @(posedge clk); #1;
            set_ext(alt, 1'b0);
        end
        as_n = 1'b0; cs_n = 1'b0;
        t_int = (dram || port == 2'b11) ? INF : waits + 2;
        t_ext = (dram || ext_at <= 0) ? INF : ext_at + (alt ? 2 : 1);
        ext_won = (t_ext <= t_int);
        t_end = ext_won ? t_ext : t_int;
        lim = (t_end >= INF) ? 20 : t_end + 1;
        enc = (port == 2'b00) ? 2'b00 : (port == 2'b01) ? 2'b01 : 2'b10;
        for (int k = 1; k <= lim; k++) begin
            @(posedge clk); #1;
            drv = (k >= t_end) && !ext_won;
            chk(req, outs(), {drv && !alt, (drv && !alt) ? enc : 2'b11,
                              drv && alt, !(drv && alt), k == t_end});
            if (k >= t_end) chk({req, " src"}, {5'b0, done_ext}, {5'b0, ext_won});
            if (k == ext_at) set_ext(alt, 1'b1);
        end
        as_n = 1'b1; cs_n = 1'b1;
        set_ext(alt, 1'b0);
        @(posedge clk); #1;
        chk("R11 release", outs(), 6'b011010);
        @(posedge clk); #1;
    endtask

    initial begin
        #(8 * 100000);
        if (!finished) begin
            total++; bad++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        chk("R1 reset", outs(), 6'b011010);
        chk("R1 reset src", {5'b0, done_ext}, 6'b0);
        rst_n = 1'b1;
        @(posedge clk); #1;
        // R1: boot defaults, 32-bit with 14 wait states
        run_cyc(1'b0, 1'b0, 2'b00, 14, 1'b0, -1, 1'b0, "R1 boot");
        // R2 R3 R6: sweep of internal widths, wait counts and bus modes
        for (int p = 0; p < 3; p++)
            for (int w = 0; w < 4; w++)
                for (int a = 0; a < 2; a++)
                    run_cyc(1'b1, 1'b0, 2'(p), w * 5, a[0], -1, 1'b0,
                            a ? "R2/R6/R12" : "R2/R3/R12");
        // R4: external-only setting, both bus modes
        run_cyc(1'b1, 1'b0, 2'b11, 0, 1'b0, 1, 1'b0, "R4/R5");
        run_cyc(1'b1, 1'b0, 2'b11, 0, 1'b0, 3, 1'b0, "R4/R5");
        run_cyc(1'b1, 1'b0, 2'b11, 2, 1'b1, 1, 1'b0, "R4/R7");
        run_cyc(1'b1, 1'b0, 2'b11, 2, 1'b1, 3, 1'b0, "R4/R7");
        // R5 R7: early external acknowledge with internal port
        run_cyc(1'b1, 1'b0, 2'b01, 9, 1'b0, 2, 1'b0, "R5 early");
        run_cyc(1'b1, 1'b0, 2'b10, 9, 1'b1, 2, 1'b0, "R7 early");
        // R5: tie between external and internal, external wins
        run_cyc(1'b1, 1'b0, 2'b00, 3, 1'b0, 4, 1'b0, "R5 tie");
        // R8: acknowledge present only before chip select
        run_cyc(1'b1, 1'b0, 2'b00, 2, 1'b1, -1, 1'b1, "R8 ta");
        run_cyc(1'b1, 1'b0, 2'b01, 2, 1'b0, -1, 1'b1, "R8 pair");
        // R9: DRAM bank type
        run_cyc(1'b1, 1'b1, 2'b00, 2, 1'b0, -1, 1'b0, "R9 dram");
        run_cyc(1'b1, 1'b1, 2'b10, 0, 1'b1, -1, 1'b0, "R9 dram");
        // R10: back to back cycles after a DRAM setting
        run_cyc(1'b1, 1'b0, 2'b10, 1, 1'b0, -1, 1'b0, "R10");
        finished = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule